// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block combines every reset request of a small microcontroller into one system reset and brings the chip back up in a fixed order. Several kinds of source can hold the chip in reset. The power-supply monitor resets the whole block. The external reset pin resets the chip once a minimum low time has been filtered. A low-voltage flag holds reset until the supply recovers. Four one-cycle fault events also cause a reset: a watchdog overflow, a trap opcode, a RAM parity error and an access to an illegal address. Each kind of source has its own release rule.

When the last source lets go, the block counts a fixed number of cycles of reset processing. It then fetches a two-byte start address over a simple request/acknowledge read port, low byte first. Only after that does it release the system reset, together with the fetched start address. While sources hold the chip, the block stops the oscillators. It selects the high-speed internal clock once the hold ends. All port pins are placed in high impedance during reset. One designated pin is pulled up or left floating, depending on the kind of the last reset. A cause register records which sources fired, and software clears it bit by bit by writing ones.

Top module: `sysrst_ctrl`

## Requirements
- R1: While `por_ok` is low, the block is in its reset state: `sys_rst_n` is 0, `clk_stop` is 1, `port_hiz` is 1, `cause` is 0 and `pin_pu` is 0. Once `por_ok` is high, the block runs a boot sequence (R6, R7) and releases `sys_rst_n`.
- R2: The reset pin causes a reset only after it has stayed low for at least ceil(MIN_LOW_NS / CLK_PERIOD_NS) clock cycles. A shorter low pulse has no effect on any output. Once accepted, the pin reset holds until the pin returns high.
- R3: A one-cycle pulse on `wdt_ovf`, `ram_par_err` or `mem_acc_err` asserts reset (`clk_stop` = 1) on the next cycle. The reset then releases by itself after EVT_HOLD_CYC more cycles.
- R4: A one-cycle `opcode_vld` with `opcode` equal to 8'hFF asserts reset in the same way as R3. The request is ignored when `dbg_mode` is 1, and any other opcode value has no effect.
- R5: A low level on `lvd_ok` holds reset, after a two-stage synchronizer, for as long as it stays low. The reset releases by itself when `lvd_ok` returns high.
- R6: Exactly PROC_CYC clock cycles pass from the fall of `clk_stop` to the rise of `vec_req`.
- R7: The vector fetch reads address 0 first and then address 1, each read completed by a `vec_ack` with the data on `vec_rdata`. `start_pc` becomes {byte at 1, byte at 0}. `sys_rst_n` rises on the cycle after the second acknowledge.
- R8: `clk_stop` is 1 exactly while sources hold the block. `hs_clk_sel` is 1 from the end of that hold onward. `port_hiz` is 1 whenever `sys_rst_n` is 0.
- R9: `pin_pu` becomes 1 after a reset from any of the watchdog, trap-opcode, parity, access or low-voltage sources. It becomes 0 after a pin reset or a power-on reset, and it keeps its value until the next reset. The pin reset wins when it coincides with another source.
- R10: The `cause` bits are: bit 0 pin, bit 1 watchdog, bit 2 low voltage, bit 3 trap opcode, bit 4 RAM parity, bit 5 illegal access. A bit is set in the cycle after its request is seen and stays set across later resets. A power-on reset clears all bits.
- R11: A one-cycle `cause_clr` clears the `cause` bits that are 1 in `cause_clr_mask` and leaves the other bits unchanged. If a source requests in the same cycle, its bit stays set.
- R12: A new request during reset processing or during the vector fetch returns the block to the hold state, and the full processing delay starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal high-speed clock |
| por_ok | input | 1 | Supply at or above the power-on level (async, low = reset) |
| rst_pin_n | input | 1 | External reset pin, active low (async) |
| lvd_ok | input | 1 | Supply at or above the low-voltage level (async) |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| opcode_vld | input | 1 | An opcode is being executed |
| opcode | input | 8 | Executed opcode byte |
| dbg_mode | input | 1 | Debug mode, suppresses the trap-opcode reset |
| ram_par_err | input | 1 | RAM parity error pulse |
| mem_acc_err | input | 1 | Illegal memory access pulse |
| vec_req | output | 1 | Vector read request |
| vec_addr | output | ADDR_W | Vector read address |
| vec_ack | input | 1 | Vector read acknowledge |
| vec_rdata | input | 8 | Vector read data |
| sys_rst_n | output | 1 | System reset, active low |
| start_pc | output | 16 | Fetched start address |
| clk_stop | output | 1 | Stop all oscillators and ignore the external clock |
| hs_clk_sel | output | 1 | Select the high-speed internal clock |
| port_hiz | output | 1 | Put the port pins in high impedance |
| pin_pu | output | 1 | Designated pin: 1 pulled up, 0 high impedance |
| cause | output | 6 | Reset cause bits |
| cause_clr | input | 1 | Write strobe that clears cause bits |
| cause_clr_mask | input | 6 | Bits to clear |

## Verification
The assertions check the per-cycle relations on every cycle:
- an event or trap opcode asserts `clk_stop` on the next cycle and sets its cause bit;
- a low `lvd_ok` reaches `clk_stop` within three cycles;
- `sys_rst_n` never rises without a preceding acknowledge;
- the processing delay has exactly PROC_CYC cycles.

Only the bench scenarios show the remaining behaviour. This covers the pin filter threshold and release, the low-voltage hold length, the pull-up choice for each source kind, the byte order of the fetched start address, the partial clear of cause bits, and the restart of the delay on a request that arrives mid-sequence.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_PROC   = 3'd1,
        ST_VEC_LO = 3'd2,
        ST_VEC_HI = 3'd3,
        ST_RUN    = 3'd4
    } seq_st_e;

    localparam int NCAUSE = 6;
    localparam int CB_PIN = 0;
    localparam int CB_WDT = 1;
    localparam int CB_LVD = 2;
    localparam int CB_ILL = 3;
    localparam int CB_PAR = 4;
    localparam int CB_MEM = 5;

    localparam logic [7:0] OPC_TRAP = 8'hFF;

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/sysrst_pinflt.sv
module sysrst_pinflt #(
    parameter int FILT_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_s,
    output logic pin_act
);
    localparam int CW = $clog2(FILT_CYC + 1) + 1;
    localparam logic [CW-1:0] FILT_V = CW'(FILT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (pin_n_s) begin
            f_d.cnt = '0;
        end else if (f_q.cnt != FILT_V) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign pin_act = (f_q.cnt == FILT_V);
endmodule

// File: rtl/sysrst_seq.sv
module sysrst_seq
    import sysrst_pkg::*;
#(
    parameter int PROC_CYC     = 16,
    parameter int EVT_HOLD_CYC = 4,
    parameter int ADDR_W       = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_lvl,
    input  logic              evt,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    input  logic              vec_ack,
    input  logic [7:0]        vec_rdata,
    output logic              sys_rst_n,
    output logic [15:0]       start_pc,
    output logic              clk_stop,
    output logic              hs_clk_sel
);
    localparam int PW = $clog2(PROC_CYC + 1) + 1;
    localparam int EW = $clog2(EVT_HOLD_CYC + 1) + 1;
    localparam logic [PW-1:0] PROC_LAST = PW'(PROC_CYC - 1);
    localparam logic [EW-1:0] EVT_V     = EW'(EVT_HOLD_CYC);

    typedef struct packed {
        seq_st_e       st;
        logic [PW-1:0] pcnt;
        logic [EW-1:0] ecnt;
        logic [7:0]    lo;
        logic [15:0]   pc;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        if (evt) begin
            s_d.ecnt = EVT_V;
        end else if (s_q.ecnt != '0) begin
            s_d.ecnt = s_q.ecnt - 1'b1;
        end

        unique case (s_q.st)
            ST_HOLD: begin
                if (!hold_lvl && !evt && (s_q.ecnt == '0)) begin
                    s_d.st   = ST_PROC;
                    s_d.pcnt = PROC_LAST;
                end
            end
            ST_PROC: begin
                if (s_q.pcnt == '0) begin
                    s_d.st = ST_VEC_LO;
                end else begin
                    s_d.pcnt = s_q.pcnt - 1'b1;
                end
            end
            ST_VEC_LO: begin
                if (vec_ack) begin
                    s_d.lo = vec_rdata;
                    s_d.st = ST_VEC_HI;
                end
            end
            ST_VEC_HI: begin
                if (vec_ack) begin
                    s_d.pc = {vec_rdata, s_q.lo};
                    s_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                s_d.st = ST_RUN;
            end
            default: begin
                s_d.st = ST_HOLD;
            end
        endcase

        if (hold_lvl || evt) begin
            s_d.st = ST_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_HOLD, pcnt: '0, ecnt: EVT_V, lo: '0, pc: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign vec_req    = (s_q.st == ST_VEC_LO) || (s_q.st == ST_VEC_HI);
    assign vec_addr   = (s_q.st == ST_VEC_HI) ? ADDR_W'(1) : '0;
    assign sys_rst_n  = (s_q.st == ST_RUN);
    assign start_pc   = s_q.pc;
    assign clk_stop   = (s_q.st == ST_HOLD);
    assign hs_clk_sel = (s_q.st != ST_HOLD);
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int MIN_LOW_NS    = 10000,
    parameter int PROC_CYC      = 16,
    parameter int EVT_HOLD_CYC  = 4,
    parameter int ADDR_W        = 20
) (
    input  logic              clk,
    input  logic              por_ok,
    input  logic              rst_pin_n,
    input  logic              lvd_ok,
    input  logic              wdt_ovf,
    input  logic              opcode_vld,
    input  logic [7:0]        opcode,
    input  logic              dbg_mode,
    input  logic              ram_par_err,
    input  logic              mem_acc_err,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    input  logic              vec_ack,
    input  logic [7:0]        vec_rdata,
    output logic              sys_rst_n,
    output logic [15:0]       start_pc,
    output logic              clk_stop,
    output logic              hs_clk_sel,
    output logic              port_hiz,
    output logic              pin_pu,
    output logic [5:0]        cause,
    input  logic              cause_clr,
    input  logic [5:0]        cause_clr_mask
);
    localparam int FILT_CYC = (MIN_LOW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    logic rst_n;
    logic pin_n_s, lvd_ok_s, pin_act;
    logic ill_req, lvd_low, evt, hold_lvl;
    logic [NCAUSE-1:0] set_vec;

    sysrst_sync #(.W(1), .RST_VAL(1'b0)) u_por_sync (
        .clk   (clk),
        .rst_n (por_ok),
        .d     (1'b1),
        .q     (rst_n)
    );

    sysrst_sync #(.W(2), .RST_VAL(2'b11)) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lvd_ok, rst_pin_n}),
        .q     ({lvd_ok_s, pin_n_s})
    );

    sysrst_pinflt #(.FILT_CYC(FILT_CYC)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_s (pin_n_s),
        .pin_act (pin_act)
    );

    assign ill_req  = opcode_vld && (opcode == OPC_TRAP) && !dbg_mode;
    assign lvd_low  = !lvd_ok_s;
    assign evt      = wdt_ovf | ill_req | ram_par_err | mem_acc_err;
    assign hold_lvl = pin_act | lvd_low;

    always_comb begin
        set_vec         = '0;
        set_vec[CB_PIN] = pin_act;
        set_vec[CB_WDT] = wdt_ovf;
        set_vec[CB_LVD] = lvd_low;
        set_vec[CB_ILL] = ill_req;
        set_vec[CB_PAR] = ram_par_err;
        set_vec[CB_MEM] = mem_acc_err;
    end

    sysrst_seq #(
        .PROC_CYC     (PROC_CYC),
        .EVT_HOLD_CYC (EVT_HOLD_CYC),
        .ADDR_W       (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_lvl   (hold_lvl),
        .evt        (evt),
        .vec_req    (vec_req),
        .vec_addr   (vec_addr),
        .vec_ack    (vec_ack),
        .vec_rdata  (vec_rdata),
        .sys_rst_n  (sys_rst_n),
        .start_pc   (start_pc),
        .clk_stop   (clk_stop),
        .hs_clk_sel (hs_clk_sel)
    );

    typedef struct packed {
        logic [NCAUSE-1:0] cause;
        logic              pu;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        c_d.cause = (c_q.cause & ~(cause_clr ? cause_clr_mask : '0)) | set_vec;
        if (pin_act) begin
            c_d.pu = 1'b0;
        end else if (|set_vec) begin
            c_d.pu = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{cause: '0, pu: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign cause    = c_q.cause;
    assign pin_pu   = c_q.pu;
    assign port_hiz = !sys_rst_n;
endmodule

// File: rtl/sysrst_chk.sv
module sysrst_chk #(
    parameter int PROC_CYC = 16
) (
    input logic       clk,
    input logic       blk_rst_n,
    input logic       lvd_ok,
    input logic       wdt_ovf,
    input logic       ram_par_err,
    input logic       mem_acc_err,
    input logic       opcode_vld,
    input logic [7:0] opcode,
    input logic       dbg_mode,
    input logic       clk_stop,
    input logic       vec_req,
    input logic       vec_ack,
    input logic       sys_rst_n,
    input logic [5:0] cause
);
    localparam int CW = $clog2(PROC_CYC + 2) + 1;
    logic [CW-1:0] gap_q;

    always_ff @(posedge clk or negedge blk_rst_n) begin
        if (!blk_rst_n) begin
            gap_q <= '0;
        end else if (clk_stop) begin
            gap_q <= '0;
        end else if (!vec_req) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R3
    evt_hold_chk: assert property (@(posedge clk) disable iff (!blk_rst_n)
        (wdt_ovf || ram_par_err || mem_acc_err) |=> clk_stop);

    // R4
    trap_opc_chk: assert property (@(posedge clk) disable iff (!blk_rst_n)
        (opcode_vld && opcode == 8'hFF && !dbg_mode) |=> (clk_stop && cause[3]));

    // R5
    lvd_hold_chk: assert property (@(posedge clk) disable iff (!blk_rst_n)
        !lvd_ok |-> ##3 clk_stop);

    // R6
    proc_len_chk: assert property (@(posedge clk) disable iff (!blk_rst_n)
        $rose(vec_req) |-> (gap_q == CW'(PROC_CYC)));

    // R7
    release_ack_chk: assert property (@(posedge clk) disable iff (!blk_rst_n)
        $rose(sys_rst_n) |-> $past(vec_ack));

    // R10
    wdt_cause_chk: assert property (@(posedge clk) disable iff (!blk_rst_n)
        wdt_ovf |=> cause[1]);
endmodule

bind sysrst_ctrl sysrst_chk #(.PROC_CYC(PROC_CYC)) u_chk (
    .clk         (clk),
    .blk_rst_n   (rst_n),
    .lvd_ok      (lvd_ok),
    .wdt_ovf     (wdt_ovf),
    .ram_par_err (ram_par_err),
    .mem_acc_err (mem_acc_err),
    .opcode_vld  (opcode_vld),
    .opcode      (opcode),
    .dbg_mode    (dbg_mode),
    .clk_stop    (clk_stop),
    .vec_req     (vec_req),
    .vec_ack     (vec_ack),
    .sys_rst_n   (sys_rst_n),
    .cause       (cause)
);

// File: tb/sysrst_ctrl_tb.sv
module sysrst_ctrl_tb;
    localparam int PROC = 16;
    localparam int FILT = (10000 + 20 - 1) / 20;

    logic clk = 1'b0;
    logic por_ok = 1'b1, rst_pin_n = 1'b1, lvd_ok = 1'b1;
    logic wdt_ovf = 1'b0, opcode_vld = 1'b0, dbg_mode = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic ram_par_err = 1'b0, mem_acc_err = 1'b0;
    logic vec_req, vec_ack = 1'b0;
    logic [19:0] vec_addr;
    logic [7:0] vec_rdata = 8'h00;
    logic sys_rst_n, clk_stop, hs_clk_sel, port_hiz, pin_pu;
    logic [15:0] start_pc;
    logic [5:0] cause;
    logic cause_clr = 1'b0;
    logic [5:0] cause_clr_mask = 6'h0;

    logic [7:0] mem_lo = 8'h00, mem_hi = 8'h00;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sysrst_ctrl u_dut (
        .clk(clk), .por_ok(por_ok), .rst_pin_n(rst_pin_n), .lvd_ok(lvd_ok),
        .wdt_ovf(wdt_ovf), .opcode_vld(opcode_vld), .opcode(opcode),
        .dbg_mode(dbg_mode), .ram_par_err(ram_par_err), .mem_acc_err(mem_acc_err),
        .vec_req(vec_req), .vec_addr(vec_addr), .vec_ack(vec_ack),
        .vec_rdata(vec_rdata), .sys_rst_n(sys_rst_n), .start_pc(start_pc),
        .clk_stop(clk_stop), .hs_clk_sel(hs_clk_sel), .port_hiz(port_hiz),
        .pin_pu(pin_pu), .cause(cause), .cause_clr(cause_clr),
        .cause_clr_mask(cause_clr_mask)
    );

    // vector memory model: one-cycle acknowledge per request
    initial begin
        forever begin
            @(negedge clk);
            if (vec_req && !vec_ack) begin
                vec_ack   = 1'b1;
                vec_rdata = (vec_addr == 20'd0) ? mem_lo :
                            (vec_addr == 20'd1) ? mem_hi : 8'h00;
            end else begin
                vec_ack = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // field layout: [25:23] source, [22:17] cause, [16] pull-up, [15:0] start address
    localparam logic [25:0] TBL [6] = '{
        {3'd0, 6'b000010, 1'b1, 16'hA001},
        {3'd5, 6'b000001, 1'b0, 16'h0B02},
        {3'd4, 6'b000100, 1'b1, 16'h1C03},
        {3'd3, 6'b100000, 1'b1, 16'h2D04},
        {3'd1, 6'b001000, 1'b1, 16'h3E05},
        {3'd2, 6'b010000, 1'b1, 16'h4F06}
    };

    task automatic fire(input int src);
        case (src)
            0: begin wdt_ovf = 1'b1; tick(1); wdt_ovf = 1'b0; end
            1: begin opcode_vld = 1'b1; opcode = 8'hFF; tick(1); opcode_vld = 1'b0; end
            2: begin ram_par_err = 1'b1; tick(1); ram_par_err = 1'b0; end
            3: begin mem_acc_err = 1'b1; tick(1); mem_acc_err = 1'b0; end
            4: begin
                lvd_ok = 1'b0; tick(30);
                chk(clk_stop == 1'b1, "R5 held while lvd low", clk_stop, 1);
                lvd_ok = 1'b1;
            end
            default: begin
                rst_pin_n = 1'b0; tick(FILT + 10);
                chk(clk_stop == 1'b1, "R2 long pin low accepted", clk_stop, 1);
                rst_pin_n = 1'b1;
            end
        endcase
    endtask

    task automatic clear_all();
        cause_clr = 1'b1; cause_clr_mask = 6'h3F; tick(1);
        cause_clr = 1'b0; cause_clr_mask = 6'h0; tick(1);
    endtask

    task automatic run_boot(input logic [15:0] pc, input string tag);
        int n = 0;
        while (clk_stop && n < 2000) begin tick(1); n++; end
        chk(hs_clk_sel == 1'b1, "R8 hs clock after hold", hs_clk_sel, 1);
        n = 0;
        while (!vec_req && n < 200) begin tick(1); n++; end
        chk(n == PROC, {"R6 processing delay ", tag}, n, PROC);
        chk(vec_addr == 20'd0, "R7 low byte first", vec_addr, 0);
        n = 0;
        while (!sys_rst_n && n < 50) begin tick(1); n++; end
        chk(sys_rst_n == 1'b1, {"R7 release ", tag}, sys_rst_n, 1);
        chk(start_pc == pc, {"R7 start address ", tag}, start_pc, pc);
        chk(port_hiz == 1'b0, "R8 ports released", port_hiz, 0);
    endtask

    initial begin
        int seen_low;
        #1 por_ok = 1'b0;
        tick(6);
        // R1 reset state
        chk(sys_rst_n == 1'b0, "R1 sys_rst_n", sys_rst_n, 0);
        chk(clk_stop == 1'b1, "R1 clk_stop", clk_stop, 1);
        chk(port_hiz == 1'b1, "R1 port_hiz", port_hiz, 1);
        chk(cause == 6'h0, "R1 cause", cause, 0);
        chk(pin_pu == 1'b0, "R1 pin_pu", pin_pu, 0);
        mem_lo = 8'h34; mem_hi = 8'h12;
        por_ok = 1'b1;
        run_boot(16'h1234, "R1 power-on boot");
        chk(cause == 6'h0 && pin_pu == 1'b0, "R1 R9 after power-on", {cause, pin_pu}, 0);

        // table of sources
        for (int i = 0; i < 6; i++) begin
            logic [25:0] e = TBL[i];
            clear_all();
            mem_lo = e[7:0]; mem_hi = e[15:8];
            fire(int'(e[25:23]));
            run_boot(e[15:0], "table");
            chk(cause == e[22:17], "R10 cause bit", cause, e[22:17]);
            chk(pin_pu == e[16], "R9 pin mode", pin_pu, e[16]);
        end

        // R3 next-cycle assertion and self release
        clear_all();
        mem_lo = 8'h66; mem_hi = 8'h55;
        wdt_ovf = 1'b1; tick(1); wdt_ovf = 1'b0;
        chk(clk_stop == 1'b1 && port_hiz == 1'b1, "R3 R8 immediate hold", clk_stop, 1);
        chk(hs_clk_sel == 1'b0, "R8 hs select off in hold", hs_clk_sel, 0);
        tick(5);
        chk(clk_stop == 1'b0, "R3 self release", clk_stop, 0);
        run_boot(16'h5566, "R3");

        // R12 retrigger during processing
        mem_lo = 8'h88; mem_hi = 8'h77;
        fire(0);
        while (clk_stop) tick(1);
        tick(4);
        fire(2);
        chk(clk_stop == 1'b1, "R12 back to hold", clk_stop, 1);
        run_boot(16'h7788, "R12");
        chk(cause == 6'b010010, "R10 bits accumulate", cause, 6'b010010);

        // R11 partial clear, and set wins over clear
        cause_clr = 1'b1; cause_clr_mask = 6'b010000; tick(1);
        cause_clr = 1'b0; tick(1);
        chk(cause == 6'b000010, "R11 partial clear", cause, 6'b000010);
        cause_clr = 1'b1; cause_clr_mask = 6'b000010; wdt_ovf = 1'b1; tick(1);
        cause_clr = 1'b0; wdt_ovf = 1'b0; tick(1);
        chk(cause[1] == 1'b1, "R11 set wins", cause[1], 1);
        run_boot(16'h7788, "R11");

        // R2 short pin pulse ignored
        clear_all();
        seen_low = 0;
        rst_pin_n = 1'b0;
        for (int i = 0; i < FILT - 10; i++) begin tick(1); if (!sys_rst_n) seen_low++; end
        rst_pin_n = 1'b1;
        for (int i = 0; i < 10; i++) begin tick(1); if (!sys_rst_n) seen_low++; end
        chk(seen_low == 0, "R2 short pulse no reset", seen_low, 0);
        chk(cause == 6'h0, "R2 short pulse no cause", cause, 0);

        // R4 debug suppression and non-trap opcode
        dbg_mode = 1'b1; opcode_vld = 1'b1; opcode = 8'hFF; tick(1);
        opcode_vld = 1'b0; dbg_mode = 1'b0; tick(4);
        chk(sys_rst_n == 1'b1 && cause == 6'h0, "R4 debug suppresses", {cause, sys_rst_n}, 1);
        opcode_vld = 1'b1; opcode = 8'hFE; tick(1);
        opcode_vld = 1'b0; tick(4);
        chk(sys_rst_n == 1'b1 && cause == 6'h0, "R4 other opcode", {cause, sys_rst_n}, 1);

        // R9 pin wins over a coincident event
        mem_lo = 8'h22; mem_hi = 8'h11;
        fire(0);
        run_boot(16'h1122, "R9 pre");
        rst_pin_n = 1'b0; tick(FILT + 2);
        mem_acc_err = 1'b1; tick(1); mem_acc_err = 1'b0; tick(4);
        rst_pin_n = 1'b1;
        run_boot(16'h1122, "R9");
        chk(pin_pu == 1'b0, "R9 pin priority", pin_pu, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule